// File: doc/BRIEF.md
# Leading-Edge Blanked Current Limiter

This block qualifies a digitized current-sense value against two programmable thresholds during each switching cycle of a PWM power stage. The sample arrives already referenced to its Kelvin return. A phase input marks the on-time (high) and the dead time (low). When the current sense crosses the lower threshold, the block asks the PWM latch to end the present pulse. When it crosses the higher threshold, the block sends a single fault pulse to the fault sequencer, which handles the soft-start restart.

Every on-time opens with a blanking window of a programmable number of clock ticks. During that window both comparators are masked, so turn-on spikes are ignored. The window timer is held cleared through dead time and starts counting at the first clock of the on-time. A disable bit removes the window completely.

Samples arrive on a valid/ready stream. The block takes a sample on every clock and never applies back-pressure, so `smp_ready` is always high. A sample is used in the clock where `smp_valid` is high. A beat with `smp_valid` low carries nothing.

Top module: `lebcl_top`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `lim_req` and `oc_fault` are 0 and the blanking timer is cleared.
- R2: With `blank_off` = 0, samples taken on the first `blank_len` rising clock edges of an on-time are ignored: neither output asserts, even if the sample exceeds both thresholds. Edges are counted from the first edge at which `phase_on` = 1.
- R3: Blanking ends at the edge with index `blank_len` (0-based) within the on-time, and comparisons are live from that edge on. A `blank_len` of 0 means no blanking.
- R4: With `blank_off` = 1, comparisons are live from the first edge of the on-time.
- R5: A live valid sample with `smp_data` >= `lim_thr` sets `lim_req` one clock later. `lim_req` then stays high for the rest of that on-time.
- R6: A live valid sample with `smp_data` >= `oc_thr` raises `oc_fault` for exactly one clock, one clock later. This happens at most once per on-time and can happen again in the next on-time.
- R7: The fault comparison is enabled only when `oc_thr` > `lim_thr`. When that ordering is violated, `oc_fault` never asserts, and `lim_req` still works as in R5.
- R8: An edge with `phase_on` = 0 (dead time) drives both outputs to 0 on the next clock and clears the blanking timer. Samples in dead time are ignored.
- R9: Beats with `smp_valid` = 0 never set an output. The blanking timer still counts clock edges during them. `smp_ready` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_on | input | 1 | 1 = on-time, 0 = dead time |
| blank_len | input | 8 | Blanking length in clock ticks |
| blank_off | input | 1 | 1 removes blanking |
| lim_thr | input | 10 | Pulse-by-pulse limit threshold code |
| oc_thr | input | 10 | Overcurrent fault threshold code |
| smp_valid | input | 1 | Sense sample valid |
| smp_data | input | 10 | Sense sample code |
| smp_ready | output | 1 | Always 1, no back-pressure |
| lim_req | output | 1 | Terminate-pulse request to the PWM latch |
| oc_fault | output | 1 | One-clock overcurrent fault pulse |

## Verification
The following properties are checked on every clock, whatever the stimulus:
- `oc_fault` never lasts two clocks.
- Dead time clears both outputs.
- `lim_req` holds through an on-time.
- A fault never appears without a limit request.
- The first edge of an on-time with nonzero blanking produces nothing.
- With blanking disabled, an over-limit sample is answered at once.

The exact edge at which blanking ends, the equality cases at each threshold, and the once-per-cycle fault rearming across cycles can only be shown by the bench's scenarios. The same holds for ignoring invalid beats while the timer keeps counting, and for suppressing the fault under a reversed threshold pair.

// File: rtl/lebcl_pkg.sv
package lebcl_pkg;
  localparam int unsigned DATA_W  = 10;
  localparam int unsigned BLANK_W = 8;

  // comparator hit vector, one bit per threshold
  typedef struct packed {
    logic oc;
    logic lim;
  } lebcl_hit_t;

  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned IDX_LIM = 0;
  localparam int unsigned IDX_OC  = 1;
endpackage

// File: rtl/lebcl_blank_timer.sv
module lebcl_blank_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_on,
  input  logic             blank_off,
  input  logic [CNT_W-1:0] blank_len,
  output logic             blanking
);
  logic [CNT_W-1:0] tick_q;
  logic             below;

  assign below    = (tick_q < blank_len);
  assign blanking = phase_on && !blank_off && below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else if (!phase_on) begin
      tick_q <= '0;
    end else if (below) begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/lebcl_cmp.sv
module lebcl_cmp #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] thr,
  input  logic              enable,
  output logic              hit
);
  assign hit = enable && vld && (data >= thr);
endmodule

// File: rtl/lebcl_resp.sv
module lebcl_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_on,
  input  logic live,
  input  lebcl_pkg::lebcl_hit_t hit,
  output logic lim_req,
  output logic oc_fault
);
  logic lim_q, oc_q, oc_seen_q;
  logic lim_set, oc_set;

  assign lim_set = live && hit.lim;
  assign oc_set  = live && hit.oc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q     <= 1'b0;
      oc_q      <= 1'b0;
      oc_seen_q <= 1'b0;
    end else if (!phase_on) begin
      lim_q     <= 1'b0;
      oc_q      <= 1'b0;
      oc_seen_q <= 1'b0;
    end else begin
      lim_q     <= lim_q || lim_set;
      oc_q      <= oc_set && !oc_seen_q;
      oc_seen_q <= oc_seen_q || oc_set;
    end
  end

  assign lim_req  = lim_q;
  assign oc_fault = oc_q;
endmodule

// File: rtl/lebcl_top.sv
module lebcl_top #(
  parameter int unsigned DATA_W  = lebcl_pkg::DATA_W,
  parameter int unsigned BLANK_W = lebcl_pkg::BLANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phase_on,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic               blank_off,
  input  logic [DATA_W-1:0]  lim_thr,
  input  logic [DATA_W-1:0]  oc_thr,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_data,
  output logic               smp_ready,
  output logic               lim_req,
  output logic               oc_fault
);
  import lebcl_pkg::*;

  logic                     blanking;
  logic                     live;
  logic                     order_ok;
  logic [NUM_CMP-1:0]       hit_vec;
  logic [NUM_CMP-1:0]       cmp_en;
  logic [DATA_W-1:0]        thr_arr [NUM_CMP];
  lebcl_hit_t               hit;

  assign smp_ready = 1'b1;
  assign order_ok  = (oc_thr > lim_thr);
  assign live      = phase_on && !blanking;

  assign thr_arr[IDX_LIM] = lim_thr;
  assign thr_arr[IDX_OC]  = oc_thr;
  assign cmp_en[IDX_LIM]  = 1'b1;
  assign cmp_en[IDX_OC]   = order_ok;

  lebcl_blank_timer #(.CNT_W(BLANK_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_on  (phase_on),
    .blank_off (blank_off),
    .blank_len (blank_len),
    .blanking  (blanking)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    lebcl_cmp #(.DATA_W(DATA_W)) cmp_i (
      .vld    (smp_valid),
      .data   (smp_data),
      .thr    (thr_arr[g]),
      .enable (cmp_en[g]),
      .hit    (hit_vec[g])
    );
  end

  assign hit.lim = hit_vec[IDX_LIM];
  assign hit.oc  = hit_vec[IDX_OC];

  lebcl_resp resp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_on (phase_on),
    .live     (live),
    .hit      (hit),
    .lim_req  (lim_req),
    .oc_fault (oc_fault)
  );
endmodule

// File: rtl/lebcl_chk.sv
module lebcl_chk #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned BLANK_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               phase_on,
  input logic [BLANK_W-1:0] blank_len,
  input logic               blank_off,
  input logic [DATA_W-1:0]  lim_thr,
  input logic               smp_valid,
  input logic [DATA_W-1:0]  smp_data,
  input logic               lim_req,
  input logic               oc_fault
);
  AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |=> !oc_fault); // R6
  AST_DEAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_on |=> (!lim_req && !oc_fault)); // R8
  AST_LIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_on && lim_req) |=> lim_req); // R5
  AST_FAULT_WITH_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    oc_fault |-> lim_req); // R7
  AST_FIRST_EDGE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase_on) && !blank_off && (blank_len != '0)) |=> (!lim_req && !oc_fault)); // R2
  AST_NOBLANK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_off && phase_on && smp_valid && (smp_data >= lim_thr)) |=> lim_req); // R4
endmodule

bind lebcl_top lebcl_chk #(.DATA_W(DATA_W), .BLANK_W(BLANK_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase_on  (phase_on),
  .blank_len (blank_len),
  .blank_off (blank_off),
  .lim_thr   (lim_thr),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .lim_req   (lim_req),
  .oc_fault  (oc_fault)
);

// File: tb/lebcl_top_tb_top.sv
module lebcl_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 23;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_on = 1'b0;
  logic [7:0] blank_len = 8'd3;
  logic       blank_off = 1'b0;
  logic [9:0] lim_thr = 10'd500;
  logic [9:0] oc_thr = 10'd800;
  logic       smp_valid = 1'b0;
  logic [9:0] smp_data = '0;
  logic       smp_ready, lim_req, oc_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lebcl_top dut_i (
    .clk(clk), .rst_n(rst_n), .phase_on(phase_on), .blank_len(blank_len),
    .blank_off(blank_off), .lim_thr(lim_thr), .oc_thr(oc_thr),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .lim_req(lim_req), .oc_fault(oc_fault)
  );

  // fields: phase, blank_off, valid, data[9:0], exp_lim, exp_oc ; lim_thr 500, oc_thr 800, blank_len 3
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0,1'b0,1'b1,10'd900,1'b0,1'b0}, // R8 dead time ignores sample
    {1'b1,1'b0,1'b1,10'd900,1'b0,1'b0}, // R2 blanked k0
    {1'b1,1'b0,1'b1,10'd900,1'b0,1'b0}, // R2 blanked k1
    {1'b1,1'b0,1'b1,10'd900,1'b0,1'b0}, // R2 blanked k2
    {1'b1,1'b0,1'b1,10'd600,1'b1,1'b0}, // R3 live at k3
    {1'b1,1'b0,1'b1,10'd100,1'b1,1'b0}, // R5 sticky
    {1'b1,1'b0,1'b1,10'd850,1'b1,1'b1}, // R6 fault pulse
    {1'b1,1'b0,1'b1,10'd900,1'b1,1'b0}, // R6 once per cycle
    {1'b0,1'b0,1'b1,10'd900,1'b0,1'b0}, // R8 clears
    {1'b1,1'b0,1'b1,10'd100,1'b0,1'b0},
    {1'b1,1'b0,1'b1,10'd100,1'b0,1'b0},
    {1'b1,1'b0,1'b1,10'd100,1'b0,1'b0},
    {1'b1,1'b0,1'b1,10'd499,1'b0,1'b0}, // R5 just below
    {1'b1,1'b0,1'b1,10'd500,1'b1,1'b0}, // R5 equal
    {1'b1,1'b0,1'b0,10'd900,1'b1,1'b0}, // R9 invalid beat
    {1'b0,1'b0,1'b1,10'd0,  1'b0,1'b0},
    {1'b1,1'b0,1'b0,10'd900,1'b0,1'b0}, // R9 timer counts invalid beats
    {1'b1,1'b0,1'b0,10'd900,1'b0,1'b0},
    {1'b1,1'b0,1'b0,10'd900,1'b0,1'b0},
    {1'b1,1'b0,1'b1,10'd800,1'b1,1'b1}, // R6 rearmed, equal threshold
    {1'b0,1'b0,1'b1,10'd0,  1'b0,1'b0},
    {1'b1,1'b1,1'b1,10'd700,1'b1,1'b0}, // R4 no blanking
    {1'b0,1'b0,1'b1,10'd0,  1'b0,1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic ph, input logic boff, input logic v, input logic [9:0] d);
    phase_on = ph; blank_off = boff; smp_valid = v; smp_data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lim_req in reset", lim_req, 1'b0);
    chk("R1 oc_fault in reset", oc_fault, 1'b0);
    chk("R9 smp_ready", smp_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:2]);
      chk($sformatf("R5 lim_req row %0d", i), lim_req, VEC[i][1]);
      chk($sformatf("R6 oc_fault row %0d", i), oc_fault, VEC[i][0]);
    end

    // R3: zero blanking length means live from first edge
    blank_len = 8'd0;
    step(1'b0, 1'b0, 1'b1, 10'd0);
    step(1'b1, 1'b0, 1'b1, 10'd600);
    chk("R3 zero length live", lim_req, 1'b1);
    step(1'b0, 1'b0, 1'b1, 10'd0);

    // R7: reversed threshold pair suppresses the fault
    lim_thr = 10'd500; oc_thr = 10'd400;
    step(1'b1, 1'b0, 1'b1, 10'd900);
    chk("R7 lim_req still works", lim_req, 1'b1);
    chk("R7 no fault reversed", oc_fault, 1'b0);
    step(1'b1, 1'b0, 1'b1, 10'd900);
    chk("R7 no fault later", oc_fault, 1'b0);
    oc_thr = 10'd500;
    step(1'b1, 1'b0, 1'b1, 10'd900);
    chk("R7 no fault equal", oc_fault, 1'b0);
    step(1'b0, 1'b0, 1'b1, 10'd0);
    oc_thr = 10'd800;

    // R1: reset mid on-time clears outputs
    step(1'b1, 1'b0, 1'b1, 10'd900);
    step(1'b1, 1'b0, 1'b1, 10'd900);
    chk("R1 pre-reset lim", lim_req, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 async lim clear", lim_req, 1'b0);
    chk("R1 async oc clear", oc_fault, 1'b0);
    // R1: timer cleared, so after release blanking restarts from zero
    blank_len = 8'd2;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, 10'd900);
    chk("R1 timer cleared k0", lim_req, 1'b0);
    step(1'b1, 1'b0, 1'b1, 10'd900);
    chk("R1 timer cleared k1", lim_req, 1'b0);
    step(1'b1, 1'b0, 1'b1, 10'd900);
    chk("R3 live at k2", lim_req, 1'b1);
    chk("R6 fault at k2", oc_fault, 1'b1);
    step(1'b0, 1'b0, 1'b1, 10'd0);
    chk("R8 dead clears", lim_req, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule